// File: doc/BRIEF.md
# Adaptive Narrowband Canceller (LMS Linear Predictor)

This block removes narrowband interference, such as a strong tone, from a wideband signal by using linear prediction. Each incoming sample is the target value. A copy of the input stream, held back by a programmable decorrelation delay, feeds a 16-tap FIR predictor. Samples that far apart stay correlated for the narrowband component only, so the predictor learns to reproduce that component. The prediction is subtracted from the incoming sample. The difference is the error, and it carries the recovered wideband signal.

After each prediction, every coefficient is adjusted with the least-mean-squares rule. The adjustment uses the error and the same tap sample that took part in the prediction. The step size is a power of two chosen by a shift input. A single multiply-accumulate datapath handles the taps in sequence, so the input stream is throttled with a valid/ready handshake. A new set of coefficients always applies to the next sample.

Top module: `lms_predictor`

## Requirements
- R1: The tap line holds past input samples. Tap k (k = 0..15) sees the sample received Δ+k samples before the current one. Δ is captured from `delay_sel` only while reset or clear is high, with 0 mapped to 1 and any value above 32 mapped to 32. Any other change of `delay_sel` has no effect.
- R2: The prediction is computed as follows. The accumulator holds acc = Σ h_k·tap_k. Then pred = sat16((acc + 2^14) >>> 15), so coefficients are signed Q1.15 values.
- R3: The error is err = sat16(x − pred), where pred is the saturated value. `err_valid` pulses high for exactly one cycle, with `err_data` and `pred_data` valid in that same cycle.
- R4: Each coefficient is updated as h_k ← sat16(h_k + ((err·tap_k) >>> (15 + mu_shift))). The shift is arithmetic and mu_shift is in the range 0..15.
- R5: The coefficients written after sample n are the ones used to predict sample n+1.
- R6: `in_ready` is high after reset. It falls in the cycle after a sample is accepted and rises again no more than 40 cycles after the accept.
- R7: Reset or a one-cycle `clr` sets every coefficient and every tap-line entry to zero. The first sample after that gives pred = 0 and err = x.
- R8: `coef_rd_data` returns h[`coef_rd_idx`] as signed Q1.15, one cycle after the index is presented. It reads 0 during reset.
- R9: For a tone plus pseudo-random wideband input, the error power measured after convergence is lower than the input power.
- R10: Full-scale input that drives the coefficients, the prediction or the error past the 16-bit range saturates to the signed limits and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of coefficients and tap line; also captures Δ |
| delay_sel | input | 6 | Decorrelation delay Δ requested (1..32) |
| mu_shift | input | 4 | Step size exponent, µ = 2^-mu_shift |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample, signed |
| err_valid | output | 1 | One-cycle strobe for err_data/pred_data |
| err_data | output | 16 | Error sample (wideband output), signed |
| pred_data | output | 16 | Prediction of the narrowband part, signed |
| coef_rd_idx | input | 4 | Coefficient readback index |
| coef_rd_data | output | 16 | Coefficient readback value, signed Q1.15 |

## Verification
Two actions share the final processing edge: the write of the last coefficient h15 and the shift of the current sample into the tap line. If the shift came first, h15 would be updated with the wrong tap sample. The bench provokes this with Δ = 1 and sample values that change on every input, so an early or late shift changes h15 and every later prediction. The result is judged against a bit-exact model of the fixed-point arithmetic, through the error output of each sample and through readback of all coefficients.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int SW   = 16;        // sample and coefficient width
  localparam int FRAC = SW - 1;    // Q1.15 fraction bits
  localparam longint SMAX = (longint'(1) << (SW - 1)) - 1;
  localparam longint SMIN = -(longint'(1) << (SW - 1));

  typedef logic signed [SW-1:0] smp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_ERR, ST_UPD} lms_state_e;

  // clamp a wide signed value into the sample range
  function automatic smp_t sat_w(input longint v);
    if (v > SMAX) return smp_t'(SMAX);
    else if (v < SMIN) return smp_t'(SMIN);
    else return smp_t'(v);
  endfunction
endpackage

// File: rtl/lms_history.sv
module lms_history #(
  parameter int DEPTH = 47,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  lms_pkg::smp_t     din,
  input  logic [IW-1:0]     rd_idx,
  output lms_pkg::smp_t     rd_data
);
  lms_pkg::smp_t line [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (shift_en) begin
      line[0] <= din;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  assign rd_data = (int'(rd_idx) < DEPTH) ? line[rd_idx] : '0;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr) |=> (line[0] == $past(din))); // R1
endmodule

// File: rtl/lms_coef_bank.sv
module lms_coef_bank #(
  parameter int TAPS = 16,
  localparam int KW = $clog2(TAPS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           wr_en,
  input  logic [KW-1:0]  wr_idx,
  input  lms_pkg::smp_t  wr_data,
  input  logic [KW-1:0]  rd_idx,
  output lms_pkg::smp_t  rd_data,
  input  logic [KW-1:0]  rb_idx,
  output lms_pkg::smp_t  rb_data
);
  lms_pkg::smp_t h [TAPS];
  logic [TAPS-1:0] nonzero;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < TAPS; i++) h[i] <= '0;
      rb_data <= '0;
    end else begin
      if (wr_en) h[wr_idx] <= wr_data;
      rb_data <= h[rb_idx];
    end
  end

  assign rd_data = h[rd_idx];

  for (genvar g = 0; g < TAPS; g++) begin : g_nz
    assign nonzero[g] = |h[g];
  end

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (nonzero == '0)); // R7
endmodule

// File: rtl/lms_predictor.sv
module lms_predictor #(
  parameter int TAPS    = 16,
  parameter int MAX_DLY = 32,
  parameter int ACC_W   = 36,
  localparam int SW     = lms_pkg::SW,
  localparam int FRAC   = lms_pkg::FRAC,
  localparam int KW     = $clog2(TAPS),
  localparam int DW     = $clog2(MAX_DLY + 1),
  localparam int DEPTH  = MAX_DLY + TAPS - 1,
  localparam int HW     = $clog2(DEPTH),
  localparam int BUSY_MAX = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [DW-1:0]        delay_sel,
  input  logic [3:0]           mu_shift,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_data,
  output logic                 err_valid,
  output logic signed [SW-1:0] err_data,
  output logic signed [SW-1:0] pred_data,
  input  logic [KW-1:0]        coef_rd_idx,
  output logic signed [SW-1:0] coef_rd_data
);
  import lms_pkg::*;

  localparam logic signed [ACC_W-1:0] RND =
    {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  lms_state_e        state;
  logic [KW-1:0]     k;
  logic [DW-1:0]     dly_q;
  smp_t              d_q;
  logic signed [ACC_W-1:0] acc, acc_rnd, y_wide, prod_ext;
  logic signed [2*SW-1:0]  prod_mac, prod_upd, upd_sh;
  smp_t              tap, coef_cur, coef_new, y_sat, e_sat;
  logic [HW-1:0]     tap_idx;
  logic              last_k, accept;
  logic [DW-1:0]     dly_clamped;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign last_k   = (k == KW'(TAPS - 1));

  always_comb begin
    dly_clamped = delay_sel;
    if (delay_sel == '0) dly_clamped = DW'(1);
    else if (delay_sel > DW'(MAX_DLY)) dly_clamped = DW'(MAX_DLY);
  end

  assign tap_idx = HW'(dly_q) + HW'(k) - HW'(1);

  lms_history #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst(rst), .clr(clr),
    .shift_en(state == ST_UPD && last_k),
    .din(d_q), .rd_idx(tap_idx), .rd_data(tap)
  );

  lms_coef_bank #(.TAPS(TAPS)) u_coef (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(state == ST_UPD), .wr_idx(k), .wr_data(coef_new),
    .rd_idx(k), .rd_data(coef_cur),
    .rb_idx(coef_rd_idx), .rb_data(coef_rd_data)
  );

  // filter product and accumulation
  assign prod_mac = coef_cur * tap;
  assign prod_ext = prod_mac;
  assign acc_rnd  = acc + RND;
  assign y_wide   = acc_rnd >>> FRAC;
  assign y_sat    = sat_w(longint'(y_wide));
  assign e_sat    = sat_w(longint'(d_q) - longint'(y_sat));

  // LMS correction, step size as a right shift
  assign prod_upd = err_data * tap;
  assign upd_sh   = prod_upd >>> (FRAC + int'(mu_shift));
  assign coef_new = sat_w(longint'(coef_cur) + longint'(upd_sh));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state     <= ST_IDLE;
      k         <= '0;
      acc       <= '0;
      d_q       <= '0;
      dly_q     <= dly_clamped;
      err_valid <= 1'b0;
      err_data  <= '0;
      pred_data <= '0;
    end else begin
      err_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          d_q   <= in_data;
          acc   <= '0;
          k     <= '0;
          state <= ST_MAC;
        end
        ST_MAC: begin
          acc <= acc + prod_ext;
          k   <= k + 1'b1;
          if (last_k) state <= ST_ERR;
        end
        ST_ERR: begin
          pred_data <= y_sat;
          err_data  <= e_sat;
          err_valid <= 1'b1;
          k         <= '0;
          state     <= ST_UPD;
        end
        ST_UPD: begin
          k <= k + 1'b1;
          if (last_k) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycles spent since the last accept, for the throughput bound
  logic [$clog2(BUSY_MAX+8)-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || clr || state == ST_IDLE) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 1'b1;
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst || clr)
    accept |=> !in_ready); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_cnt < BUSY_MAX); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid); // R3
  AST_DELAY_HELD: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(dly_q)); // R1
  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst || clr)
    $rose(err_valid) |-> !in_ready); // R3
endmodule

// File: tb/lms_predictor_bench.sv
module lms_predictor_bench;
  localparam int TAPS = 16;
  localparam int DEPTH = 47;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0;
  logic [5:0] delay_sel = 6'd2;
  logic [3:0] mu_shift = 4'd2;
  logic in_valid = 1'b0;
  logic in_ready, err_valid;
  logic signed [15:0] in_data = '0, err_data, pred_data, coef_rd_data;
  logic [3:0] coef_rd_idx = '0;

  always #4 clk = ~clk; // 125 MHz

  lms_predictor u_lms_predictor (
    .clk(clk), .rst(rst), .clr(clr), .delay_sel(delay_sel), .mu_shift(mu_shift),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .err_valid(err_valid), .err_data(err_data), .pred_data(pred_data),
    .coef_rd_idx(coef_rd_idx), .coef_rd_data(coef_rd_data)
  );

  int checks = 0, failures = 0;
  longint hist_m [DEPTH];
  longint coef_m [TAPS];
  int dly_m;
  longint last_e, last_y;

  // stimulus table: {mu_shift, sample}
  localparam logic [19:0] VEC [10] = '{
    {4'd2, 16'sd1000}, {4'd2, 16'sd3000}, {4'd2, -16'sd2000}, {4'd1, 16'sd12000},
    {4'd1, -16'sd9000}, {4'd0, 16'sd500}, {4'd0, 16'sd20000}, {4'd3, -16'sd30000},
    {4'd3, 16'sd7},    {4'd15, -16'sd4000}};

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_clear(input int dsel);
    for (int i = 0; i < DEPTH; i++) hist_m[i] = 0;
    for (int i = 0; i < TAPS; i++) coef_m[i] = 0;
    dly_m = (dsel == 0) ? 1 : (dsel > 32 ? 32 : dsel);
  endtask

  task automatic model_step(input longint x);
    longint acc = 0;
    for (int k = 0; k < TAPS; k++) acc += coef_m[k] * hist_m[dly_m - 1 + k];
    last_y = sat((acc + 16384) >>> 15);
    last_e = sat(x - last_y);
    for (int k = 0; k < TAPS; k++)
      coef_m[k] = sat(coef_m[k] + ((last_e * hist_m[dly_m - 1 + k]) >>> (15 + int'(mu_shift))));
    for (int i = DEPTH - 1; i > 0; i--) hist_m[i] = hist_m[i-1];
    hist_m[0] = x;
  endtask

  // send one sample, compare against the model, check handshake timing
  task automatic send(input logic signed [15:0] x, input string req);
    int n;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R6 ready low after accept", longint'(in_ready), 0);
    n = 1;
    while (!err_valid && n < 100) begin @(negedge clk); n++; end
    model_step(longint'(x));
    chk(err_valid && longint'(err_data) == last_e, {req, " err"}, longint'(err_data), last_e);
    chk(longint'(pred_data) == last_y, "R2 prediction", longint'(pred_data), last_y);
    while (!in_ready && n < 100) begin @(negedge clk); n++; end
    chk(n <= 40, "R6 busy bound", n, 40);
  endtask

  task automatic pulse_clear(input logic [5:0] dsel);
    @(negedge clk);
    delay_sel = dsel; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear(int'(dsel));
  endtask

  task automatic readback_all(input string req);
    for (int i = 0; i < TAPS; i++) begin
      @(negedge clk); coef_rd_idx = 4'(i);
      @(negedge clk);
      chk(longint'(coef_rd_data) == coef_m[i], req, longint'(coef_rd_data), coef_m[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    longint ep, xp;
    logic [15:0] lfsr;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(in_ready, "R6 ready after reset", longint'(in_ready), 1);
    chk(!err_valid, "R3 no strobe in reset", longint'(err_valid), 0);
    chk(coef_rd_data == 0, "R8 readback zero in reset", longint'(coef_rd_data), 0);
    rst = 1'b0;
    model_clear(2);

    // table walk: R2 R3 R4 R5 with various step sizes
    foreach (VEC[i]) begin
      mu_shift = VEC[i][19:16];
      send(VEC[i][15:0], "R4 table");
    end
    readback_all("R8 readback after table");

    // R1: changing delay_sel without clear has no effect
    delay_sel = 6'd7; mu_shift = 4'd2;
    for (int i = 0; i < 6; i++) send(16'(i * 1500 - 4000), "R1 delay change ignored");

    // R7: clear zeroes state, first error equals input
    pulse_clear(6'd0);
    readback_all("R7 coefficients cleared");
    send(16'sd4321, "R7 first after clear");
    chk(err_data == 16'sd4321 && pred_data == 0, "R7 err equals input", longint'(err_data), 4321);

    // R1: delay above range clamps to 32; R5 shared-edge corner with delay 1
    pulse_clear(6'd40); mu_shift = 4'd0;
    for (int i = 0; i < 40; i++) send(16'((i % 7) * 2000 - 6000), "R1 clamp 32");
    pulse_clear(6'd1); mu_shift = 4'd1;
    for (int i = 0; i < 12; i++) send(16'((i * 5101) % 20000 - 10000), "R5 next sample");
    readback_all("R5 coefficients after delay 1");

    // R10: full-scale drive saturates
    pulse_clear(6'd1); mu_shift = 4'd0;
    for (int i = 0; i < 6; i++) send(16'sd32767, "R10 positive full scale");
    for (int i = 0; i < 6; i++) send(-16'sd32768, "R10 negative full scale");
    readback_all("R10 saturated coefficients");

    // R9: tone plus pseudo-random wideband, power after convergence
    pulse_clear(6'd2); mu_shift = 4'd3;
    lfsr = 16'hACE1; ep = 0; xp = 0;
    for (int n = 0; n < 800; n++) begin
      logic signed [15:0] xs;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xs = 16'($rtoi(8000.0 * $sin(6.283185307 * n / 16.0)) + int'(lfsr[9:0]) - 512);
      send(xs, "R9 tone run");
      if (n >= 544) begin
        ep += longint'(err_data) * longint'(err_data);
        xp += longint'(xs) * longint'(xs);
      end
    end
    chk(ep < xp, "R9 error power below input power", ep, xp);

    finish_run();
  end
endmodule